// File: doc/BRIEF.md
# Packed Halfword Multiply-Accumulate Unit

A pipelined multiply-accumulate datapath for filter and audio kernels. Each operation takes two 32-bit operands, forms a signed product in one of three modes and adds it into a private 40-bit accumulator. The 40-bit width leaves eight guard bits above a 32-bit result. The multiplier array forms a 16-bit by 32-bit product per pass. The modes are a full 32x32 multiply-accumulate, a packed mode that adds both signed halfword-by-halfword products, and a mode that multiplies one chosen halfword of each operand.

Operations enter through a valid/ready handshake, and single-pass operations can issue every cycle. A full-width operation whose multiplier operand needs more than 16 significant bits takes a second pass through the array. This holds the input for one cycle and adds one cycle of latency. A full-width operation with a short multiplier operand terminates early. A done strobe marks the retirement of each operation. The accumulator is loaded through a write port. The read port acts as a fence: it answers only after every operation accepted earlier has retired.

Top module: `simdMacUnit`

## Requirements
- R1: After reset the accumulator is zero, `opReady` is 1, and `doneStrobe` and `accRdValid` are 0.
- R2: Operations with opcode 1, 2 or 3 never lower `opReady` on their own. A stream of them is accepted on consecutive cycles.
- R3: Opcode 0 adds the signed 32x32 product of `opA` and `opB` into the accumulator.
- R4: A single-pass operation accepted at clock edge k (opcode 0 with `opB` between -32768 and 32767, or any other opcode) updates the accumulator at edge k+2. It raises `doneStrobe` for the one cycle after edge k+2.
- R5: Opcode 0 with `opB` outside the signed 16-bit range holds `opReady` low for the cycle after it is accepted. It completes at edge k+3, and `doneStrobe` is high for the cycle after that edge.
- R6: Opcode 1 adds the sum of the signed products of the low halves (bits 15:0) and of the high halves (bits 31:16) of the two operands.
- R7: Opcode 2 adds the signed product of one halfword of each operand. `opSel[0]`=1 takes bits 31:16 of `opA`, otherwise bits 15:0. `opSel[1]` picks the half of `opB` in the same way.
- R8: Opcode 3 leaves the accumulator unchanged but still retires with a done strobe at the single-pass time.
- R9: `accWrEn` loads the accumulator with {`accWrHi`,`accWrLo`} at the clock edge. If a pass retires at that same edge, the written value wins and that pass's contribution is discarded.
- R10: `accRdReq` produces a one-cycle `accRdValid`, together with the accumulator value, only after every operation accepted before or in the same cycle as the request has retired. `opReady` is low while a request waits. `accRdLo` holds bits 31:0. `accRdHi` holds bits 39:32, sign-extended to 32 bits.
- R11: The accumulator wraps modulo 2^40 without saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Operation can be taken this cycle |
| opCode | input | 2 | 0 full MAC, 1 dual halfword, 2 halfword select, 3 no-op |
| opSel | input | 2 | Halfword selectors for opcode 2 |
| opA | input | 32 | Multiplicand operand |
| opB | input | 32 | Multiplier operand |
| accWrEn | input | 1 | Load the accumulator |
| accWrLo | input | 32 | Value for accumulator bits 31:0 |
| accWrHi | input | 8 | Value for accumulator bits 39:32 |
| accRdReq | input | 1 | Request a fenced accumulator read |
| accRdValid | output | 1 | Read data valid strobe |
| accRdLo | output | 32 | Accumulator bits 31:0 |
| accRdHi | output | 32 | Accumulator bits 39:32, sign-extended |
| doneStrobe | output | 1 | An operation retired |

## Verification
Two pairs of functions can fall into the same cycle. An accumulator write can land on the edge where a pass retires. A read request can arrive in the cycle an operation is accepted. The bench forces the first pair by issuing a single-pass operation and writing exactly two edges later. It judges the result by the fenced read value, which must equal the written value, and by the done strobe, which must still appear. The second pair is provoked by raising both `opValid` and `accRdReq` together. The read must then return the sum that includes that operation. A cycle-accurate behavioural model is compared against `opReady`, `doneStrobe` and the read port on every cycle, through both directed and random traffic.

// File: rtl/macPkg.sv
package macPkg;

  typedef enum logic [1:0] {
    OP_MAC32 = 2'd0,
    OP_DUAL  = 2'd1,
    OP_HALF  = 2'd2,
    OP_NONE  = 2'd3
  } macOp_e;

  typedef struct packed {
    logic loadOp;   // capture a new operation into the array stage
    logic passHi;   // array works on the upper multiplier half
    logic issue;    // array stage holds work, register its addend
    logic retire;   // addend stage holds work, add it in
    logic wrAcc;    // load the accumulator from the write port
    logic capRead;  // capture the accumulator onto the read port
  } macStrobe_t;

endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic       needsTwo,
  input  logic       accWrEn,
  input  logic       accRdReq,
  output logic       opReady,
  output logic       doneStrobe,
  output logic       accRdValid,
  output macStrobe_t strobe
);

  logic s1Valid, passIdx, s2Valid, s2Last, rdPend;
  logic s1Done, opFire, rdDue;

  assign s1Done  = s1Valid && (passIdx || !needsTwo);
  assign opReady = !rdPend && (!s1Valid || s1Done);
  assign opFire  = opValid && opReady;
  assign rdDue   = (rdPend || accRdReq) && !s1Valid && !s2Valid && !opFire;

  always_comb begin
    strobe.loadOp  = opFire;
    strobe.passHi  = s1Valid && passIdx;
    strobe.issue   = s1Valid;
    strobe.retire  = s2Valid;
    strobe.wrAcc   = accWrEn;
    strobe.capRead = rdDue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid    <= 1'b0;
      passIdx    <= 1'b0;
      s2Valid    <= 1'b0;
      s2Last     <= 1'b0;
      rdPend     <= 1'b0;
      doneStrobe <= 1'b0;
      accRdValid <= 1'b0;
    end else begin
      if (opFire) begin
        s1Valid <= 1'b1;
        passIdx <= 1'b0;
      end else if (s1Done) begin
        s1Valid <= 1'b0;
        passIdx <= 1'b0;
      end else if (s1Valid) begin
        passIdx <= 1'b1;
      end
      s2Valid    <= s1Valid;
      s2Last     <= s1Done;
      doneStrobe <= s2Valid && s2Last;
      accRdValid <= rdDue;
      rdPend     <= (rdPend || accRdReq) && !rdDue;
    end
  end

  // Single-pass work never blocks the next issue
  assert_back_to_back_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opFire && opCode != 2'd0 && !accRdReq) |=> opReady);

  // A wide multiplier operand holds the input and then runs its upper pass
  assert_second_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !passIdx && needsTwo) |-> (!opReady ##1 (s1Valid && passIdx)));

  // Fenced read only reports on an empty pipeline
  assert_read_drained_R10: assert property (@(posedge clk) disable iff (!rstN)
    accRdValid |-> (!s1Valid && !s2Valid));

  // Single-pass opcodes retire with a strobe three edges after acceptance
  assert_early_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opFire && opCode != 2'd0) |-> ##3 doneStrobe);

endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  macStrobe_t          strobe,
  input  logic [1:0]          opCode,
  input  logic [1:0]          opSel,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   accWrLo,
  input  logic [GUARD_W-1:0]  accWrHi,
  output logic                needsTwo,
  output logic [DATA_W-1:0]   accRdLo,
  output logic [DATA_W-1:0]   accRdHi
);

  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = DATA_W + GUARD_W;
  localparam int PROD_W = DATA_W + HALF_W + 1;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] aReg, bReg;
  macOp_e            opcReg;
  logic [1:0]        selReg;
  logic [ACC_W-1:0]  addendReg, accReg, addendNext;

  // Upper multiplier bits that only repeat the halfword sign need no second pass
  logic [DATA_W-HALF_W:0] upperBits;
  assign upperBits = bReg[DATA_W-1:HALF_W-1];
  assign needsTwo  = (opcReg == OP_MAC32) && !((&upperBits) || !(|upperBits));

  // Full-width pass through the 16x32 array
  logic signed [DATA_W-1:0] aSigned;
  logic signed [HALF_W:0]   bPart;
  logic signed [PROD_W-1:0] wideProd;
  logic [ACC_W-1:0]         macTerm;

  assign aSigned = aReg;

  always_comb begin
    if (!needsTwo)
      bPart = {bReg[HALF_W-1], bReg[HALF_W-1:0]};
    else if (strobe.passHi)
      bPart = {bReg[DATA_W-1], bReg[DATA_W-1:HALF_W]};
    else
      bPart = {1'b0, bReg[HALF_W-1:0]};
    wideProd = PROD_W'(aSigned) * PROD_W'(bPart);
    macTerm  = wideProd[ACC_W-1:0];
    if (strobe.passHi)
      macTerm = macTerm << HALF_W;
  end

  // Packed halfword lanes
  logic signed [DATA_W-1:0] laneProd [LANES];
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic signed [HALF_W-1:0] laneA, laneB;
    assign laneA = aReg[ln*HALF_W +: HALF_W];
    assign laneB = bReg[ln*HALF_W +: HALF_W];
    assign laneProd[ln] = DATA_W'(laneA) * DATA_W'(laneB);
  end

  logic [ACC_W-1:0] dualSum;
  assign dualSum = ACC_W'(laneProd[0]) + ACC_W'(laneProd[1]);

  // Halfword-select product
  logic signed [HALF_W-1:0] selA, selB;
  logic signed [DATA_W-1:0] selProd;
  assign selA    = selReg[0] ? aReg[DATA_W-1:HALF_W] : aReg[HALF_W-1:0];
  assign selB    = selReg[1] ? bReg[DATA_W-1:HALF_W] : bReg[HALF_W-1:0];
  assign selProd = DATA_W'(selA) * DATA_W'(selB);

  always_comb begin
    unique case (opcReg)
      OP_MAC32: addendNext = macTerm;
      OP_DUAL:  addendNext = dualSum;
      OP_HALF:  addendNext = ACC_W'(selProd);
      default:  addendNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg      <= '0;
      bReg      <= '0;
      opcReg    <= OP_NONE;
      selReg    <= '0;
      addendReg <= '0;
      accReg    <= '0;
      accRdLo   <= '0;
      accRdHi   <= '0;
    end else begin
      if (strobe.loadOp) begin
        aReg   <= opA;
        bReg   <= opB;
        opcReg <= macOp_e'(opCode);
        selReg <= opSel;
      end
      if (strobe.issue)
        addendReg <= addendNext;
      if (strobe.wrAcc)
        accReg <= {accWrHi, accWrLo};
      else if (strobe.retire)
        accReg <= accReg + addendReg;
      if (strobe.capRead) begin
        accRdLo <= accReg[DATA_W-1:0];
        accRdHi <= DATA_W'($signed(accReg[ACC_W-1:DATA_W]));
      end
    end
  end

  // The upper pass is only ever requested for a wide full-width operation
  assert_hi_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passHi |-> (needsTwo && opcReg == OP_MAC32));

endmodule

// File: rtl/simdMacUnit.sv
module simdMacUnit
  import macPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  output logic               opReady,
  input  logic [1:0]         opCode,
  input  logic [1:0]         opSel,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               accWrEn,
  input  logic [DATA_W-1:0]  accWrLo,
  input  logic [GUARD_W-1:0] accWrHi,
  input  logic               accRdReq,
  output logic               accRdValid,
  output logic [DATA_W-1:0]  accRdLo,
  output logic [DATA_W-1:0]  accRdHi,
  output logic               doneStrobe
);

  macStrobe_t strobe;
  logic       needsTwo;

  macCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opCode     (opCode),
    .needsTwo   (needsTwo),
    .accWrEn    (accWrEn),
    .accRdReq   (accRdReq),
    .opReady    (opReady),
    .doneStrobe (doneStrobe),
    .accRdValid (accRdValid),
    .strobe     (strobe)
  );

  macDatapath #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opCode   (opCode),
    .opSel    (opSel),
    .opA      (opA),
    .opB      (opB),
    .accWrLo  (accWrLo),
    .accWrHi  (accWrHi),
    .needsTwo (needsTwo),
    .accRdLo  (accRdLo),
    .accRdHi  (accRdHi)
  );

endmodule

// File: tb/simdMacUnit_tb.sv
module simdMacUnit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, accWrEn, accRdReq;
  logic [1:0]  opCode, opSel;
  logic [31:0] opA, opB, accWrLo;
  logic [7:0]  accWrHi;
  logic        opReady, accRdValid, doneStrobe;
  logic [31:0] accRdLo, accRdHi;

  always #4 clk = ~clk;

  simdMacUnit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opCode(opCode), .opSel(opSel), .opA(opA), .opB(opB),
    .accWrEn(accWrEn), .accWrLo(accWrLo), .accWrHi(accWrHi),
    .accRdReq(accRdReq), .accRdValid(accRdValid), .accRdLo(accRdLo),
    .accRdHi(accRdHi), .doneStrobe(doneStrobe)
  );

  localparam longint MASK40 = (64'sd1 <<< 40) - 64'sd1;

  int     checks = 0, errors = 0, cyc = 0, evCount = 0;
  longint accM = 0, expRd = 0;
  bit     evV [8];
  longint evAdd [8];
  bit     evLast [8];
  bit     rdPendM = 0, busy2M = 0, expReady = 1, expDone = 0, expRdV = 0, lastFire = 0;
  string  tag = "R1";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint addendOf(input logic [1:0] op, input logic [1:0] sel,
                                      input logic [31:0] a, input logic [31:0] b);
    longint p;
    logic [15:0] ha, hb;
    case (op)
      2'd0: p = longint'($signed(a)) * longint'($signed(b));
      2'd1: p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]))
              + longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
      2'd2: begin
        ha = sel[0] ? a[31:16] : a[15:0];
        hb = sel[1] ? b[31:16] : b[15:0];
        p = longint'($signed(ha)) * longint'($signed(hb));
      end
      default: p = 0;
    endcase
    return p & MASK40;
  endfunction

  function automatic bit isTwoPass(input logic [1:0] op, input logic [31:0] b);
    return (op == 2'd0) && (($signed(b) > 32767) || ($signed(b) < -32768));
  endfunction

  // One clock of stimulus and model, inputs already driven, called off the edge
  task automatic step();
    bit fire, due, pendEff, evNow, two;
    int t;
    longint add;
    chk(opReady === expReady, "opReady", longint'(opReady), longint'(expReady));
    fire = opValid && expReady;
    two  = isTwoPass(opCode, opB);
    add  = addendOf(opCode, opSel, opA, opB);
    @(posedge clk);
    cyc++;
    t = cyc;
    pendEff = rdPendM || accRdReq;
    due     = pendEff && !fire && (evCount == 0);
    expRdV  = due;
    if (due) expRd = accM;
    evNow   = evV[t % 8];
    expDone = evNow && evLast[t % 8];
    if (accWrEn) accM = (longint'(accWrHi) << 32) | longint'(accWrLo);
    else if (evNow) accM = (accM + evAdd[t % 8]) & MASK40;
    if (evNow) begin
      evV[t % 8] = 0;
      evCount--;
    end
    if (fire) begin
      if (two) begin
        evV[(t + 2) % 8] = 1; evAdd[(t + 2) % 8] = 0;   evLast[(t + 2) % 8] = 0;
        evV[(t + 3) % 8] = 1; evAdd[(t + 3) % 8] = add; evLast[(t + 3) % 8] = 1;
        evCount += 2;
      end else begin
        evV[(t + 2) % 8] = 1; evAdd[(t + 2) % 8] = add; evLast[(t + 2) % 8] = 1;
        evCount += 1;
      end
    end
    lastFire = fire;
    busy2M   = fire && two;
    rdPendM  = pendEff && !due;
    expReady = !rdPendM && !busy2M;
    @(negedge clk);
    chk(doneStrobe === expDone, "doneStrobe", longint'(doneStrobe), longint'(expDone));
    chk(accRdValid === expRdV, "accRdValid", longint'(accRdValid), longint'(expRdV));
    if (expRdV) begin
      chk(accRdLo === expRd[31:0], "accRdLo", longint'(accRdLo), expRd & 64'hFFFF_FFFF);
      chk(accRdHi === {{24{expRd[39]}}, expRd[39:32]}, "accRdHi", longint'(accRdHi),
          longint'({{24{expRd[39]}}, expRd[39:32]}));
    end
  endtask

  task automatic clearIn();
    opValid = 0; accWrEn = 0; accRdReq = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] sel,
                       input logic [31:0] a, input logic [31:0] b);
    opValid = 1; opCode = op; opSel = sel; opA = a; opB = b;
    do step(); while (!lastFire);
    opValid = 0;
  endtask

  task automatic writeAcc(input logic [7:0] hi, input logic [31:0] lo);
    accWrEn = 1; accWrHi = hi; accWrLo = lo;
    step();
    accWrEn = 0;
  endtask

  task automatic readAcc();
    accRdReq = 1;
    step();
    accRdReq = 0;
    while (rdPendM) step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin evV[i] = 0; evAdd[i] = 0; evLast[i] = 0; end
    rstN = 0; clearIn();
    opCode = 0; opSel = 0; opA = 0; opB = 0; accWrLo = 0; accWrHi = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tag = "R1";
    chk(opReady === 1'b1, "reset opReady", longint'(opReady), 1);
    chk(doneStrobe === 1'b0, "reset doneStrobe", longint'(doneStrobe), 0);
    chk(accRdValid === 1'b0, "reset accRdValid", longint'(accRdValid), 0);
    readAcc();

    tag = "R4";   // early-terminated full MAC, boundary of the 16-bit range
    issue(2'd0, 2'd0, 32'h1234_5678, 32'hFFFF_8000);
    issue(2'd0, 2'd0, 32'h8000_0001, 32'h0000_7FFF);
    idle(4); readAcc();

    tag = "R5";   // just outside the 16-bit range forces a second pass
    issue(2'd0, 2'd0, 32'h0000_0003, 32'h0000_8000);
    issue(2'd0, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF);
    issue(2'd0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_7FFF);
    idle(5); readAcc();

    tag = "R3";
    issue(2'd0, 2'd0, 32'hDEAD_BEEF, 32'h0123_4567);
    issue(2'd0, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000);
    idle(5); readAcc();

    tag = "R6";
    issue(2'd1, 2'd0, 32'h8000_7FFF, 32'h8000_8000);
    issue(2'd1, 2'd0, 32'h1234_FFFF, 32'hFFFE_0002);
    idle(4); readAcc();

    tag = "R7";
    for (int s = 0; s < 4; s++) issue(2'd2, s[1:0], 32'h0003_FFF9, 32'hFFFB_0007);
    idle(4); readAcc();

    tag = "R8";
    issue(2'd3, 2'd0, 32'h7FFF_7FFF, 32'h7FFF_7FFF);
    idle(4); readAcc();

    tag = "R2";   // consecutive single-pass stream
    issue(2'd1, 2'd0, 32'h0001_0002, 32'h0003_0004);
    issue(2'd2, 2'd3, 32'h0005_0006, 32'h0007_0008);
    issue(2'd0, 2'd0, 32'h0000_0010, 32'h0000_0011);
    issue(2'd1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(2'd3, 2'd0, 32'h0, 32'h0);
    issue(2'd2, 2'd1, 32'h8000_8000, 32'h8000_8000);
    idle(4); readAcc();

    tag = "R11";
    writeAcc(8'h7F, 32'hFFFF_FFFF);
    issue(2'd0, 2'd0, 32'h1, 32'h1);
    idle(4); readAcc();
    writeAcc(8'hFF, 32'hFFFF_FFFF);
    issue(2'd2, 2'd0, 32'h1, 32'h1);
    idle(4); readAcc();

    tag = "R9";   // write lands on the retiring edge of a single-pass op
    writeAcc(8'h00, 32'h0);
    issue(2'd1, 2'd0, 32'h0010_0010, 32'h0010_0010);
    step();
    writeAcc(8'h12, 32'h3456_789A);
    idle(3); readAcc();

    tag = "R10";  // read raised in the same cycle an op is accepted
    opValid = 1; opCode = 2'd0; opSel = 0; opA = 32'h0000_1000; opB = 32'h0001_0000;
    accRdReq = 1;
    step();
    clearIn();
    while (rdPendM) step();
    idle(2);

    tag = "R3";   // random traffic across all modes
    for (int i = 0; i < 2500; i++) begin
      clearIn();
      opValid = ($urandom_range(0, 3) != 0);
      opCode  = 2'($urandom_range(0, 3));
      opSel   = 2'($urandom_range(0, 3));
      opA     = $urandom();
      opB     = ($urandom_range(0, 1) == 1) ? 32'($signed(16'($urandom()))) : $urandom();
      accRdReq = ($urandom_range(0, 15) == 0);
      if (evCount == 0 && $urandom_range(0, 31) == 0) begin
        accWrEn = 1; accWrHi = 8'($urandom()); accWrLo = $urandom();
      end
      step();
    end
    clearIn();
    idle(5); readAcc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule